// File: doc/BRIEF.md
# Long Integer Divide Unit

This block is the multi-cycle divider of a 32-bit processor datapath. A request carries a low operand word, a high operand word, a divisor, the incoming condition flags and three controls: signed or unsigned arithmetic, a 64-bit dividend or a 32-bit one, and whether the quotient and remainder go to the same destination register. When `go_i` is accepted, the unit works through one quotient bit per clock using a non-restoring radix-2 iteration on magnitudes. A final fix-up cycle then applies the signs, judges overflow and forms the flags. The result is a quotient word, a remainder word, the updated flags and two write-enable strobes for the register file, all presented during a one-cycle `fin_o` pulse.

A zero divisor is caught the cycle after the request. It raises `dz_o` in place of a result, and no write strobe is given. The unit does not fetch instructions, decode addressing modes, vector exceptions or hold architectural registers. It only returns the values to write back and the strobes.

Flags are carried as a 5-bit vector: bit 4 is X (extend), bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.

Top module: `ldiv_unit`

## Requirements
- R1: With `dvsr_i` equal to zero, `fin_o` pulses one cycle after `go_i` is accepted. At the same time `dz_o` is 1, both write strobes are 0, and `flg_o` equals `flg_i`.
- R2: With `wide_i`=1 the dividend is `{hi_i, lo_i}`. With `wide_i`=0 it is `lo_i`, sign-extended when `sgn_i`=1 and zero-extended otherwise. Without overflow, the low 32 bits of the quotient appear on `quo_o` with `wq_o`=1, and the remainder appears on `rem_o`.
- R3: In unsigned mode (`sgn_i`=0), the result overflows when the quotient is larger than 2^32-1.
- R4: In signed mode, the result overflows when bits 63:31 of the 64-bit two's-complement quotient are neither all zeros nor all ones. Quotient -2^31 therefore fits, and +2^31 overflows.
- R5: On overflow, V (bit 1) is 1 and C (bit 0) is 0, while X, N and Z (bits 4, 3, 2) are copied from `flg_i`. `wq_o` and `wr_o` are both 0.
- R6: Without overflow, V and C are 0 and X is copied from `flg_i`. Z is 1 exactly when the 32-bit quotient is zero, and N equals quotient bit 31.
- R7: Without overflow, `wr_o` is 1 only when `same_i`=0. With `same_i`=1 only the quotient strobe `wq_o` is given.
- R8: In signed mode the quotient truncates toward zero, and a nonzero remainder takes the sign of the dividend.
- R9: A nonzero-divisor request gives `fin_o` exactly 66 cycles after the accepting clock edge, for one cycle. `busy_o` is 1 from the cycle after acceptance until `fin_o` rises, and it is 0 while `fin_o` is 1.
- R10: A `go_i` pulse while `busy_o` is 1 is ignored. The pending result is the one for the first request, and no extra `fin_o` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Request strobe, accepted when not busy |
| sgn_i | input | 1 | 1 = signed divide |
| wide_i | input | 1 | 1 = 64-bit dividend {hi_i, lo_i} |
| same_i | input | 1 | Quotient and remainder target the same register |
| lo_i | input | 32 | Low dividend word |
| hi_i | input | 32 | High dividend word (wide mode) |
| dvsr_i | input | 32 | Divisor |
| flg_i | input | 5 | Incoming flags {X,N,Z,V,C} |
| busy_o | output | 1 | Division in progress |
| fin_o | output | 1 | One-cycle completion pulse |
| dz_o | output | 1 | Divide-by-zero indication, valid with fin_o |
| quo_o | output | 32 | Quotient word |
| rem_o | output | 32 | Remainder word |
| flg_o | output | 5 | Resulting flags {X,N,Z,V,C} |
| wq_o | output | 1 | Write strobe for the quotient register |
| wr_o | output | 1 | Write strobe for the remainder register |

## Verification
On every cycle, the assertions check the following. A completion pulse lasts one cycle and never overlaps busy. A divide-by-zero completion carries no write strobes. An overflow completion has V set, C clear and no writes. A remainder strobe always comes with a quotient strobe. A non-overflow completion has Z and N consistent with the quotient word. Only the bench's scenarios can show the rest: the arithmetic values of quotient and remainder, the signed overflow boundary at ±2^31, the sign of the remainder, narrow-mode extension, the exact 66-cycle latency, and that a request issued while busy leaves the first result intact.

// File: rtl/ldiv_pkg.sv
package ldiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_FIX  = 2'd2
    } ldiv_st_e;

    localparam int FLG_X = 4;
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;
    localparam int FLG_W = 5;
endpackage

// File: rtl/ldiv_operand_prep.sv
module ldiv_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0]   lo_i,
    input  logic [W-1:0]   hi_i,
    input  logic [W-1:0]   dvsr_i,
    input  logic           sgn_i,
    input  logic           wide_i,
    output logic [2*W-1:0] nmag_o,
    output logic [W-1:0]   dmag_o,
    output logic           nneg_o,
    output logic           dneg_o
);
    localparam int DW = 2 * W;

    logic [DW-1:0] full;

    always_comb begin
        if (wide_i)
            full = {hi_i, lo_i};
        else if (sgn_i)
            full = {{W{lo_i[W-1]}}, lo_i};
        else
            full = {{W{1'b0}}, lo_i};
        nneg_o = sgn_i & full[DW-1];
        dneg_o = sgn_i & dvsr_i[W-1];
        nmag_o = nneg_o ? (~full + 1'b1) : full;
        dmag_o = dneg_o ? (~dvsr_i + 1'b1) : dvsr_i;
    end
endmodule

// File: rtl/ldiv_nr_step.sv
module ldiv_nr_step #(
    parameter int W = 32
) (
    input  logic [W+1:0]   p_i,
    input  logic [2*W-1:0] a_i,
    input  logic [W-1:0]   d_i,
    output logic [W+1:0]   p_o,
    output logic [2*W-1:0] a_o
);
    localparam int DW = 2 * W;

    logic [W+1:0] shifted;
    logic [W+1:0] dext;

    always_comb begin
        shifted = {p_i[W:0], a_i[DW-1]};
        dext    = {2'b00, d_i};
        if (p_i[W+1])
            p_o = shifted + dext;
        else
            p_o = shifted - dext;
        a_o = {a_i[DW-2:0], ~p_o[W+1]};
    end
endmodule

// File: rtl/ldiv_result_fix.sv
module ldiv_result_fix
    import ldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2*W-1:0]   qmag_i,
    input  logic             pneg_i,
    input  logic [W-1:0]     plow_i,
    input  logic [W-1:0]     d_i,
    input  logic             sgn_i,
    input  logic             nneg_i,
    input  logic             dneg_i,
    input  logic             same_i,
    input  logic [FLG_W-1:0] flg_i,
    output logic [W-1:0]     quo_o,
    output logic [W-1:0]     rem_o,
    output logic [FLG_W-1:0] flg_o,
    output logic             wq_o,
    output logic             wr_o
);
    localparam int DW = 2 * W;

    logic [DW-1:0]  q64;
    logic [W-1:0]   rmag;
    logic [DW-W:0]  top_bits;
    logic           ovf;

    always_comb begin
        rmag     = pneg_i ? (plow_i + d_i) : plow_i;
        q64      = (sgn_i && (nneg_i ^ dneg_i)) ? (~qmag_i + 1'b1) : qmag_i;
        rem_o    = (sgn_i && nneg_i) ? (~rmag + 1'b1) : rmag;
        quo_o    = q64[W-1:0];
        top_bits = q64[DW-1:W-1];
        if (sgn_i)
            ovf = !((&top_bits) || !(|top_bits));
        else
            ovf = |q64[DW-1:W];
        flg_o        = '0;
        flg_o[FLG_X] = flg_i[FLG_X];
        if (ovf) begin
            flg_o[FLG_N] = flg_i[FLG_N];
            flg_o[FLG_Z] = flg_i[FLG_Z];
            flg_o[FLG_V] = 1'b1;
            wq_o         = 1'b0;
            wr_o         = 1'b0;
        end else begin
            flg_o[FLG_N] = q64[W-1];
            flg_o[FLG_Z] = (q64[W-1:0] == '0);
            wq_o         = 1'b1;
            wr_o         = !same_i;
        end
    end
endmodule

// File: rtl/ldiv_unit.sv
module ldiv_unit
    import ldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             sgn_i,
    input  logic             wide_i,
    input  logic             same_i,
    input  logic [W-1:0]     lo_i,
    input  logic [W-1:0]     hi_i,
    input  logic [W-1:0]     dvsr_i,
    input  logic [FLG_W-1:0] flg_i,
    output logic             busy_o,
    output logic             fin_o,
    output logic             dz_o,
    output logic [W-1:0]     quo_o,
    output logic [W-1:0]     rem_o,
    output logic [FLG_W-1:0] flg_o,
    output logic             wq_o,
    output logic             wr_o
);
    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW);

    typedef struct packed {
        ldiv_st_e         st;
        logic [CW-1:0]    cnt;
        logic [W+1:0]     p;
        logic [DW-1:0]    a;
        logic [W-1:0]     d;
        logic             sgn;
        logic             nneg;
        logic             dneg;
        logic             same;
        logic [FLG_W-1:0] fin_flg;
        logic [W-1:0]     quo;
        logic [W-1:0]     rem;
        logic [FLG_W-1:0] flg;
        logic             wq;
        logic             wr;
        logic             dz;
        logic             fin;
    } ldiv_s_t;

    ldiv_s_t s_d, s_q;

    logic [DW-1:0]    nmag;
    logic [W-1:0]     dmag;
    logic             nneg, dneg;
    logic [W+1:0]     step_p;
    logic [DW-1:0]    step_a;
    logic [W-1:0]     fx_quo, fx_rem;
    logic [FLG_W-1:0] fx_flg;
    logic             fx_wq, fx_wr;

    ldiv_operand_prep #(.W(W)) u_prep (
        .lo_i   (lo_i),
        .hi_i   (hi_i),
        .dvsr_i (dvsr_i),
        .sgn_i  (sgn_i),
        .wide_i (wide_i),
        .nmag_o (nmag),
        .dmag_o (dmag),
        .nneg_o (nneg),
        .dneg_o (dneg)
    );

    ldiv_nr_step #(.W(W)) u_step (
        .p_i (s_q.p),
        .a_i (s_q.a),
        .d_i (s_q.d),
        .p_o (step_p),
        .a_o (step_a)
    );

    ldiv_result_fix #(.W(W)) u_fix (
        .qmag_i (s_q.a),
        .pneg_i (s_q.p[W+1]),
        .plow_i (s_q.p[W-1:0]),
        .d_i    (s_q.d),
        .sgn_i  (s_q.sgn),
        .nneg_i (s_q.nneg),
        .dneg_i (s_q.dneg),
        .same_i (s_q.same),
        .flg_i  (s_q.fin_flg),
        .quo_o  (fx_quo),
        .rem_o  (fx_rem),
        .flg_o  (fx_flg),
        .wq_o   (fx_wq),
        .wr_o   (fx_wr)
    );

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        s_d.dz  = 1'b0;
        s_d.wq  = 1'b0;
        s_d.wr  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (go_i) begin
                    if (dvsr_i == '0) begin
                        s_d.fin = 1'b1;
                        s_d.dz  = 1'b1;
                        s_d.flg = flg_i;
                    end else begin
                        s_d.st      = ST_CALC;
                        s_d.cnt     = CW'(DW - 1);
                        s_d.p       = '0;
                        s_d.a       = nmag;
                        s_d.d       = dmag;
                        s_d.sgn     = sgn_i;
                        s_d.nneg    = nneg;
                        s_d.dneg    = dneg;
                        s_d.same    = same_i;
                        s_d.fin_flg = flg_i;
                    end
                end
            end
            ST_CALC: begin
                s_d.p = step_p;
                s_d.a = step_a;
                if (s_q.cnt == '0)
                    s_d.st = ST_FIX;
                else
                    s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_FIX: begin
                s_d.quo = fx_quo;
                s_d.rem = fx_rem;
                s_d.flg = fx_flg;
                s_d.wq  = fx_wq;
                s_d.wr  = fx_wr;
                s_d.fin = 1'b1;
                s_d.st  = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '{st: ST_IDLE, default: '0};
        else
            s_q <= s_d;
    end

    assign busy_o = (s_q.st != ST_IDLE);
    assign fin_o  = s_q.fin;
    assign dz_o   = s_q.dz;
    assign quo_o  = s_q.quo;
    assign rem_o  = s_q.rem;
    assign flg_o  = s_q.flg;
    assign wq_o   = s_q.wq;
    assign wr_o   = s_q.wr;
endmodule

// File: rtl/ldiv_unit_chk.sv
module ldiv_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy_o,
    input logic         fin_o,
    input logic         dz_o,
    input logic [W-1:0] quo_o,
    input logic [4:0]   flg_o,
    input logic         wq_o,
    input logic         wr_o
);
    a_r1_dz_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_o && dz_o) |-> (!wq_o && !wr_o));

    a_r5_ovf_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_o && !dz_o && flg_o[1]) |-> (!wq_o && !wr_o && !flg_o[0]));

    a_r6_ok_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_o && !dz_o && !flg_o[1]) |->
        (wq_o && !flg_o[0] && (flg_o[2] == (quo_o == '0)) && (flg_o[3] == quo_o[W-1])));

    a_r7_rem_needs_quo: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> (wq_o && fin_o));

    a_r9_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o);

    a_r9_fin_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> !busy_o);
endmodule

bind ldiv_unit ldiv_unit_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_o (busy_o),
    .fin_o  (fin_o),
    .dz_o   (dz_o),
    .quo_o  (quo_o),
    .flg_o  (flg_o),
    .wq_o   (wq_o),
    .wr_o   (wr_o)
);

// File: tb/ldiv_unit_tb.sv
module ldiv_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go_i = 1'b0, sgn_i = 1'b0, wide_i = 1'b0, same_i = 1'b0;
    logic [31:0] lo_i = '0, hi_i = '0, dvsr_i = '0;
    logic [4:0]  flg_i = '0;
    logic        busy_o, fin_o, dz_o, wq_o, wr_o;
    logic [31:0] quo_o, rem_o;
    logic [4:0]  flg_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ldiv_unit u_dut (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .sgn_i(sgn_i), .wide_i(wide_i),
        .same_i(same_i), .lo_i(lo_i), .hi_i(hi_i), .dvsr_i(dvsr_i), .flg_i(flg_i),
        .busy_o(busy_o), .fin_o(fin_o), .dz_o(dz_o), .quo_o(quo_o), .rem_o(rem_o),
        .flg_o(flg_o), .wq_o(wq_o), .wr_o(wr_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Runs one request and compares outputs on every cycle until completion.
    task automatic run(input bit s, input bit w, input bit same, input logic [31:0] lo,
                       input logic [31:0] hi, input logic [31:0] den, input logic [4:0] fl,
                       input bit poke, input string tag);
        logic [63:0] full, nm, qm, q64;
        logic [31:0] dm, rm, er;
        logic        nn, dn, ovf;
        logic [4:0]  ef;
        logic        ewq, ewr;
        int          lat;
        if (w) full = {hi, lo};
        else if (s) full = {{32{lo[31]}}, lo};
        else full = {32'b0, lo};
        nn = s & full[63];
        dn = s & den[31];
        nm = nn ? -full : full;
        dm = dn ? -den : den;
        if (den != 0) begin
            qm = nm / {32'b0, dm};
            rm = 32'(nm % {32'b0, dm});
        end else begin
            qm = '0; rm = '0;
        end
        q64 = (s && (nn ^ dn)) ? -qm : qm;
        er  = (s && nn) ? -rm : rm;
        if (s) ovf = !((q64[63:31] == '0) || (&q64[63:31]));
        else   ovf = (q64[63:32] != 0);
        if (ovf) begin
            ef = {fl[4], fl[3], fl[2], 1'b1, 1'b0}; ewq = 0; ewr = 0;
        end else begin
            ef = {fl[4], q64[31], q64[31:0] == 0, 1'b0, 1'b0}; ewq = 1; ewr = !same;
        end
        lat = (den == 0) ? 1 : 66;

        @(negedge clk);
        go_i = 1; sgn_i = s; wide_i = w; same_i = same;
        lo_i = lo; hi_i = hi; dvsr_i = den; flg_i = fl;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            go_i = 0;
            if (poke && k == 5) begin
                go_i = 1; sgn_i = ~s; lo_i = 32'h1234_5678; hi_i = 0; dvsr_i = 32'd3; flg_i = ~fl;
            end
            chk(fin_o == (k == lat), {tag, " R9/R10 fin timing"}, 64'(fin_o), 64'(k == lat));
            if (k < lat && den != 0)
                chk(busy_o == 1'b1, {tag, " R9 busy"}, 64'(busy_o), 64'd1);
        end
        chk(busy_o == 1'b0, {tag, " R9 idle at fin"}, 64'(busy_o), 64'd0);
        if (den == 0) begin
            chk(dz_o == 1'b1, {tag, " R1 dz"}, 64'(dz_o), 64'd1);
            chk(!wq_o && !wr_o, {tag, " R1 no writes"}, {wq_o, wr_o}, 64'd0);
            chk(flg_o == fl, {tag, " R1 flags"}, 64'(flg_o), 64'(fl));
        end else begin
            chk(dz_o == 1'b0, {tag, " R1 no dz"}, 64'(dz_o), 64'd0);
            chk(flg_o == ef, {tag, " R3/R4/R5/R6 flags"}, 64'(flg_o), 64'(ef));
            chk(wq_o == ewq, {tag, " R2/R5 quotient strobe"}, 64'(wq_o), 64'(ewq));
            chk(wr_o == ewr, {tag, " R5/R7 remainder strobe"}, 64'(wr_o), 64'(ewr));
            if (!ovf) begin
                chk(quo_o == q64[31:0], {tag, " R2/R8 quotient"}, 64'(quo_o), 64'(q64[31:0]));
                chk(rem_o == er, {tag, " R2/R8 remainder"}, 64'(rem_o), 64'(er));
            end
        end
        @(negedge clk);
        chk(fin_o == 1'b0, {tag, " R9/R10 single pulse"}, 64'(fin_o), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!fin_o && !busy_o && !wq_o && !wr_o && !dz_o, "reset state",
            {fin_o, busy_o, wq_o, wr_o, dz_o}, 64'd0);
        rst_n = 1;
        run(0, 1, 0, 32'h0000_0007, 32'h0000_0001, 32'h0000_0010, 5'b10000, 0, "R2 unsigned wide");
        run(0, 1, 0, 32'h0, 32'h0000_0005, 32'h0000_0005, 5'b01100, 0, "R3 unsigned overflow");
        run(0, 1, 0, 32'hFFFF_FFFF, 32'h0000_0004, 32'h0000_0005, 5'b00000, 0, "R3 unsigned max fit");
        run(1, 1, 0, 32'hFFFF_FF00, 32'hFFFF_FFFF, 32'h0000_0007, 5'b00000, 0, "R8 signed neg dividend");
        run(1, 0, 0, 32'd100, 32'd0, 32'hFFFF_FFF9, 5'b10000, 0, "R8 signed neg divisor");
        run(1, 1, 0, 32'h8000_0000, 32'hFFFF_FFFF, 32'd1, 5'b00000, 0, "R4 quotient -2^31 fits");
        run(1, 1, 0, 32'h8000_0000, 32'h0, 32'd1, 5'b11100, 0, "R4 quotient +2^31 overflows");
        run(1, 0, 0, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 5'b00000, 0, "R4 narrow min/-1");
        run(0, 0, 0, 32'd3, 32'hDEAD_BEEF, 32'd9, 5'b00011, 0, "R6 zero quotient");
        run(0, 0, 1, 32'd1000, 32'h0, 32'd7, 5'b00000, 0, "R7 same register");
        run(1, 0, 0, 32'hFFFF_FFF0, 32'h5555_5555, 32'd3, 5'b00000, 0, "R2 narrow sign-extend");
        run(0, 0, 0, 32'hFFFF_FFF0, 32'h5555_5555, 32'd3, 5'b00000, 0, "R2 narrow zero-extend");
        run(0, 1, 0, 32'd5, 32'd5, 32'd0, 5'b01010, 0, "R1 divide by zero");
        run(0, 1, 0, 32'h89AB_CDEF, 32'h0123_4567, 32'h0BAD_F00D, 5'b10000, 1, "R10 go while busy");
        summary();
    end
endmodule